// File: doc/BRIEF.md
# Power Domain Low-Power Mode Sequencer

This block sits in the always-on wakeup region of a chip and runs from the slow 32 kHz wakeup clock, so it keeps running while the system clock is stopped. It holds one small controller for each switchable power domain. Each controller turns a requested domain state into four control lines: clock enable, isolation, retention and power. It changes them one step at a time, in a fixed safe order, and waits a set number of cycles after each step.

Above the domain controllers, a device-level sequencer moves the whole chip among run, standby and shutdown. An inactivity timer counts cycles with no activity. When it expires, the sequencer either puts every domain into retention (standby) or starts a full shutdown. A full shutdown first asks an agent to save the system context, and it cuts power only if the saved context is reported valid. It then switches every domain off, holds external memory in self-refresh and turns the regulators off. The regulator command goes out on either a dedicated pin or a request to an I2C command port. A wake event brings the chip back through the regulator-on command and a wakeup reset pulse. The same wake event aborts any power-down still in progress.

Top module: `pm_sequencer`

## Requirements
- R1: After reset every domain is active (clock enable 1, isolation 0, retention 0, power 1), the device mode is run (00), and ctx_save_req, mem_selfref, reg_off_gpio, i2c_req and wake_rst are all 0.
- R2: Each domain takes a 2-bit state code: 00 active (clock on, powered), 01 inactive (clock off, powered), 10 retention (clock off, isolated, retention on, powered), 11 off (clock off, isolated, retention off, power off).
- R3: When going down, a domain stops the clock, then asserts isolation, then asserts retention if the target needs it, then removes power (removing power also drops retention). When going up it restores power, releases retention, releases isolation and then starts the clock. Each step changes one line, except power removal.
- R4: Two successive changes of one domain's control lines are at least STEP_DLY+1 clock cycles apart.
- R5: In run mode the device leaves run on the IDLE_CYC-th consecutive cycle with activity low. Any cycle with activity high restarts the count.
- R6: On a timeout with sel_shutdown low, the device enters standby (mode 01) and every domain moves to retention.
- R7: On a timeout with sel_shutdown high, ctx_save_req rises and is held until ctx_save_ack. If ctx_valid is low at the acknowledge, the device falls back to standby instead of shutdown.
- R8: After a valid save, every domain goes off and mem_selfref is set (mode 10). Once all domains have settled off, the regulators are cut. With use_gpio high this is done by raising reg_off_gpio. With use_gpio low it is done by i2c_req with i2c_cmd_on = 0, held until i2c_ack.
- R9: A wake event in shutdown first turns the regulators back on: reg_off_gpio drops, or an i2c_req with i2c_cmd_on = 1 is held until i2c_ack. Then wake_rst is high for exactly RST_CYC cycles (mode 11). After that the device returns to run, mem_selfref clears and the domains rise to their requested states.
- R10: A wake event during context save, standby or shutdown domain sequencing returns the device to run. Any domain part-way through its sequence reverses toward its requested state at its next step, and the regulators are never cut.
- R11: Outside run mode the per-domain requests have no effect on the domain control lines.
- R12: At all times retention implies isolation and power, and a running clock implies power and no isolation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on wakeup clock |
| rst | input | 1 | Synchronous active-high reset |
| dom_req | input | 2*NUM_DOM | Requested state per domain in run mode, 2 bits each |
| activity | input | 1 | High while there is processing or user input |
| wake_evt | input | 1 | Wake event |
| sel_shutdown | input | 1 | Timeout goes to shutdown (1) or standby (0) |
| use_gpio | input | 1 | Regulator command through the dedicated pin (1) or the I2C port (0) |
| ctx_save_ack | input | 1 | Context-save agent finished |
| ctx_valid | input | 1 | Saved context is valid |
| i2c_ack | input | 1 | I2C command port accepted the command |
| ctx_save_req | output | 1 | Request to save context to external memory |
| mem_selfref | output | 1 | Hold external memory in self-refresh |
| reg_off_gpio | output | 1 | Regulator-off pin |
| i2c_req | output | 1 | Regulator command request to the I2C port |
| i2c_cmd_on | output | 1 | Command payload: 1 turn on, 0 turn off |
| wake_rst | output | 1 | Wakeup reset pulse |
| dev_mode | output | 2 | 00 run, 01 standby, 10 shutdown, 11 wakeup reset |
| dom_clk_en | output | NUM_DOM | Per-domain clock enable |
| dom_iso | output | NUM_DOM | Per-domain isolation |
| dom_ret | output | NUM_DOM | Per-domain retention |
| dom_pwr | output | NUM_DOM | Per-domain power |
| dom_settled | output | NUM_DOM | Domain has reached its target and its step wait is over |

## Verification
The handshake assertions assume that the context-save agent and the I2C port raise their acknowledge only while the matching request is high. They also assume that no wake event arrives during a save request when the test is checking that the request is held. The bench pulses ctx_save_ack and i2c_ack for one cycle, and only after it has seen the request. It raises wake_evt only at the points where a test needs it. A scoreboard holds the expected sequence of one domain's control patterns and compares it with each change as it happens, including the reversal after an aborted power-down.

// File: rtl/pmseq_pkg.sv
package pmseq_pkg;

    typedef enum logic [1:0] {
        PD_ACTIVE   = 2'b00,
        PD_INACTIVE = 2'b01,
        PD_RETAIN   = 2'b10,
        PD_OFF      = 2'b11
    } pd_state_e;

    typedef struct packed {
        logic clk_en;
        logic iso;
        logic ret;
        logic pwr;
    } pd_ctl_t;

    typedef enum logic [1:0] {
        TGT_SW,
        TGT_RET,
        TGT_OFF
    } tgt_sel_e;

    typedef enum logic [3:0] {
        S_RUN,
        S_SAVE,
        S_STBY,
        S_SD_DOWN,
        S_REG_OFF,
        S_OFF,
        S_REG_ON,
        S_WRST
    } dev_state_e;

    typedef enum logic [1:0] {
        DM_RUN  = 2'b00,
        DM_STBY = 2'b01,
        DM_SHUT = 2'b10,
        DM_WRST = 2'b11
    } dev_mode_e;

    function automatic pd_ctl_t pd_target(pd_state_e s);
        pd_ctl_t t;
        case (s)
            PD_ACTIVE:   t = '{clk_en: 1'b1, iso: 1'b0, ret: 1'b0, pwr: 1'b1};
            PD_INACTIVE: t = '{clk_en: 1'b0, iso: 1'b0, ret: 1'b0, pwr: 1'b1};
            PD_RETAIN:   t = '{clk_en: 1'b0, iso: 1'b1, ret: 1'b1, pwr: 1'b1};
            default:     t = '{clk_en: 1'b0, iso: 1'b1, ret: 1'b0, pwr: 1'b0};
        endcase
        return t;
    endfunction

    // One safe step from cur toward tgt: lowering steps take priority over raising steps.
    function automatic pd_ctl_t pd_step(pd_ctl_t cur, pd_ctl_t tgt);
        pd_ctl_t n;
        n = cur;
        if (cur.clk_en && !tgt.clk_en)
            n.clk_en = 1'b0;
        else if (!cur.iso && tgt.iso && !cur.clk_en)
            n.iso = 1'b1;
        else if (!cur.ret && tgt.ret && cur.pwr && cur.iso)
            n.ret = 1'b1;
        else if (cur.pwr && !tgt.pwr && cur.iso && !cur.clk_en) begin
            n.pwr = 1'b0;
            n.ret = 1'b0;
        end
        else if (!cur.pwr && tgt.pwr)
            n.pwr = 1'b1;
        else if (cur.ret && !tgt.ret)
            n.ret = 1'b0;
        else if (cur.iso && !tgt.iso && !cur.ret)
            n.iso = 1'b0;
        else if (!cur.clk_en && tgt.clk_en && !cur.iso && cur.pwr)
            n.clk_en = 1'b1;
        return n;
    endfunction

endpackage

// File: rtl/pd_domain_ctrl.sv
module pd_domain_ctrl
    import pmseq_pkg::*;
#(
    parameter int STEP_DLY = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  pd_state_e tgt_state,
    output pd_ctl_t   ctl,
    output logic      settled
);
    localparam int CW = $clog2(STEP_DLY + 2);
    localparam logic [CW-1:0] DLY = CW'(STEP_DLY);

    pd_ctl_t        cur_q;
    pd_ctl_t        tgt;
    pd_ctl_t        nxt;
    logic [CW-1:0]  wait_q;

    always_comb begin
        tgt = pd_target(tgt_state);
        nxt = pd_step(cur_q, tgt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= pd_target(PD_ACTIVE);
            wait_q <= '0;
        end else if (wait_q != '0) begin
            wait_q <= wait_q - 1'b1;
        end else if (nxt != cur_q) begin
            cur_q  <= nxt;
            wait_q <= DLY;
        end
    end

    assign ctl     = cur_q;
    assign settled = (cur_q == tgt) && (wait_q == '0);
endmodule

// File: rtl/pm_idle_timer.sv
module pm_idle_timer #(
    parameter int IDLE_CYC = 327680
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic activity,
    output logic timeout
);
    localparam int TW = $clog2(IDLE_CYC + 1);
    localparam logic [TW-1:0] LAST = TW'(IDLE_CYC - 1);

    logic [TW-1:0] cnt_q;

    assign timeout = en && !activity && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !en || activity || timeout)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pm_dev_seq.sv
module pm_dev_seq
    import pmseq_pkg::*;
#(
    parameter int RST_CYC = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      timeout,
    input  logic      wake,
    input  logic      sel_shutdown,
    input  logic      use_gpio,
    input  logic      ctx_ack,
    input  logic      ctx_valid,
    input  logic      i2c_ack,
    input  logic      all_settled,
    output tgt_sel_e  tgt_sel,
    output logic      timer_en,
    output logic      ctx_save_req,
    output logic      mem_selfref,
    output logic      reg_off_gpio,
    output logic      i2c_req,
    output logic      i2c_cmd_on,
    output logic      wake_rst,
    output dev_mode_e mode
);
    localparam int RW = $clog2(RST_CYC + 1);
    localparam logic [RW-1:0] RLAST = RW'(RST_CYC - 1);

    dev_state_e    st_q, st_d;
    logic          via_gpio_q;
    logic [RW-1:0] rcnt_q;

    always_comb begin
        st_d = st_q;
        case (st_q)
            S_RUN:     if (timeout) st_d = sel_shutdown ? S_SAVE : S_STBY;
            S_SAVE:    if (wake) st_d = S_RUN;
                       else if (ctx_ack) st_d = ctx_valid ? S_SD_DOWN : S_STBY;
            S_STBY:    if (wake) st_d = S_RUN;
            S_SD_DOWN: if (wake) st_d = S_RUN;
                       else if (all_settled) st_d = S_REG_OFF;
            S_REG_OFF: if (via_gpio_q || i2c_ack) st_d = S_OFF;
            S_OFF:     if (wake) st_d = S_REG_ON;
            S_REG_ON:  if (via_gpio_q || i2c_ack) st_d = S_WRST;
            S_WRST:    if (rcnt_q == RLAST) st_d = S_RUN;
            default:   st_d = S_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= S_RUN;
            via_gpio_q <= 1'b0;
            rcnt_q     <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == S_SD_DOWN && st_d == S_REG_OFF)
                via_gpio_q <= use_gpio;
            if (st_q == S_WRST)
                rcnt_q <= rcnt_q + 1'b1;
            else
                rcnt_q <= '0;
        end
    end

    always_comb begin
        case (st_q)
            S_RUN, S_SAVE: tgt_sel = TGT_SW;
            S_STBY:        tgt_sel = TGT_RET;
            default:       tgt_sel = TGT_OFF;
        endcase
        case (st_q)
            S_RUN, S_SAVE:                       mode = DM_RUN;
            S_STBY:                              mode = DM_STBY;
            S_SD_DOWN, S_REG_OFF, S_OFF, S_REG_ON: mode = DM_SHUT;
            default:                             mode = DM_WRST;
        endcase
    end

    assign timer_en     = (st_q == S_RUN);
    assign ctx_save_req = (st_q == S_SAVE);
    assign mem_selfref  = (st_q == S_SD_DOWN) || (st_q == S_REG_OFF) || (st_q == S_OFF)
                       || (st_q == S_REG_ON) || (st_q == S_WRST);
    assign reg_off_gpio = via_gpio_q && (st_q == S_OFF);
    assign i2c_req      = !via_gpio_q && ((st_q == S_REG_OFF) || (st_q == S_REG_ON));
    assign i2c_cmd_on   = (st_q == S_REG_ON);
    assign wake_rst     = (st_q == S_WRST);
endmodule

// File: rtl/pm_sequencer.sv
module pm_sequencer
    import pmseq_pkg::*;
#(
    parameter int NUM_DOM  = 4,
    parameter int STEP_DLY = 3,
    parameter int IDLE_CYC = 327680,
    parameter int RST_CYC  = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [2*NUM_DOM-1:0] dom_req,
    input  logic                 activity,
    input  logic                 wake_evt,
    input  logic                 sel_shutdown,
    input  logic                 use_gpio,
    input  logic                 ctx_save_ack,
    input  logic                 ctx_valid,
    input  logic                 i2c_ack,
    output logic                 ctx_save_req,
    output logic                 mem_selfref,
    output logic                 reg_off_gpio,
    output logic                 i2c_req,
    output logic                 i2c_cmd_on,
    output logic                 wake_rst,
    output logic [1:0]           dev_mode,
    output logic [NUM_DOM-1:0]   dom_clk_en,
    output logic [NUM_DOM-1:0]   dom_iso,
    output logic [NUM_DOM-1:0]   dom_ret,
    output logic [NUM_DOM-1:0]   dom_pwr,
    output logic [NUM_DOM-1:0]   dom_settled
);
    tgt_sel_e  tgt_sel;
    dev_mode_e mode;
    logic      timer_en;
    logic      timeout;

    pm_idle_timer #(.IDLE_CYC(IDLE_CYC)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .en       (timer_en),
        .activity (activity),
        .timeout  (timeout)
    );

    pm_dev_seq #(.RST_CYC(RST_CYC)) u_dev (
        .clk          (clk),
        .rst          (rst),
        .timeout      (timeout),
        .wake         (wake_evt),
        .sel_shutdown (sel_shutdown),
        .use_gpio     (use_gpio),
        .ctx_ack      (ctx_save_ack),
        .ctx_valid    (ctx_valid),
        .i2c_ack      (i2c_ack),
        .all_settled  (&dom_settled),
        .tgt_sel      (tgt_sel),
        .timer_en     (timer_en),
        .ctx_save_req (ctx_save_req),
        .mem_selfref  (mem_selfref),
        .reg_off_gpio (reg_off_gpio),
        .i2c_req      (i2c_req),
        .i2c_cmd_on   (i2c_cmd_on),
        .wake_rst     (wake_rst),
        .mode         (mode)
    );

    assign dev_mode = mode;

    for (genvar i = 0; i < NUM_DOM; i++) begin : g_dom
        pd_state_e tgt;
        pd_ctl_t   ctl;

        always_comb begin
            case (tgt_sel)
                TGT_SW:  tgt = pd_state_e'(dom_req[2*i +: 2]);
                TGT_RET: tgt = PD_RETAIN;
                default: tgt = PD_OFF;
            endcase
        end

        pd_domain_ctrl #(.STEP_DLY(STEP_DLY)) u_pd (
            .clk       (clk),
            .rst       (rst),
            .tgt_state (tgt),
            .ctl       (ctl),
            .settled   (dom_settled[i])
        );

        assign dom_clk_en[i] = ctl.clk_en;
        assign dom_iso[i]    = ctl.iso;
        assign dom_ret[i]    = ctl.ret;
        assign dom_pwr[i]    = ctl.pwr;
    end
endmodule

// File: rtl/pm_sequencer_chk.sv
module pm_sequencer_chk #(
    parameter int NUM_DOM = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               ctx_save_req,
    input logic               ctx_save_ack,
    input logic               wake_evt,
    input logic               mem_selfref,
    input logic               reg_off_gpio,
    input logic               i2c_req,
    input logic               i2c_cmd_on,
    input logic               i2c_ack,
    input logic               wake_rst,
    input logic [NUM_DOM-1:0] dom_clk_en,
    input logic [NUM_DOM-1:0] dom_iso,
    input logic [NUM_DOM-1:0] dom_ret,
    input logic [NUM_DOM-1:0] dom_pwr
);
    AST_RET_GUARDED: assert property (@(posedge clk) disable iff (rst)
        (dom_ret & ~(dom_iso & dom_pwr)) == '0);                                  // R12
    AST_CLK_GUARDED: assert property (@(posedge clk) disable iff (rst)
        (dom_clk_en & (dom_iso | ~dom_pwr)) == '0);                               // R12
    AST_GPIO_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
        reg_off_gpio |-> (dom_pwr == '0));                                        // R8
    AST_I2C_OFF_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
        (i2c_req && !i2c_cmd_on) |-> (dom_pwr == '0));                            // R8
    AST_I2C_HELD: assert property (@(posedge clk) disable iff (rst)
        (i2c_req && !i2c_ack) |=> i2c_req);                                       // R8
    AST_CUT_IN_SELFREF: assert property (@(posedge clk) disable iff (rst)
        $rose(reg_off_gpio) |-> mem_selfref);                                     // R8
    AST_SAVE_HELD: assert property (@(posedge clk) disable iff (rst)
        (ctx_save_req && !ctx_save_ack && !wake_evt) |=> ctx_save_req);           // R7
    AST_WRST_REG_ON: assert property (@(posedge clk) disable iff (rst)
        wake_rst |-> (!reg_off_gpio && !i2c_req));                                // R9
endmodule

bind pm_sequencer pm_sequencer_chk #(.NUM_DOM(NUM_DOM)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ctx_save_req (ctx_save_req),
    .ctx_save_ack (ctx_save_ack),
    .wake_evt     (wake_evt),
    .mem_selfref  (mem_selfref),
    .reg_off_gpio (reg_off_gpio),
    .i2c_req      (i2c_req),
    .i2c_cmd_on   (i2c_cmd_on),
    .i2c_ack      (i2c_ack),
    .wake_rst     (wake_rst),
    .dom_clk_en   (dom_clk_en),
    .dom_iso      (dom_iso),
    .dom_ret      (dom_ret),
    .dom_pwr      (dom_pwr)
);

// File: tb/test_pm_sequencer.sv
module test_pm_sequencer;
    localparam int ND = 2;
    localparam int SD = 2;
    localparam int IC = 20;
    localparam int RC = 3;

    // pattern bits {clk_en, iso, ret, pwr}
    localparam logic [3:0] P_ACT = 4'b1001;
    localparam logic [3:0] P_CK0 = 4'b0001;
    localparam logic [3:0] P_ISO = 4'b0101;
    localparam logic [3:0] P_RET = 4'b0111;
    localparam logic [3:0] P_OFF = 4'b0100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2*ND-1:0] dom_req = '0;
    logic activity = 1'b1, wake_evt = 1'b0, sel_shutdown = 1'b0, use_gpio = 1'b0;
    logic ctx_save_ack = 1'b0, ctx_valid = 1'b0, i2c_ack = 1'b0;
    logic ctx_save_req, mem_selfref, reg_off_gpio, i2c_req, i2c_cmd_on, wake_rst;
    logic [1:0] dev_mode;
    logic [ND-1:0] dom_clk_en, dom_iso, dom_ret, dom_pwr, dom_settled;

    int n_chk = 0;
    int n_fail = 0;
    logic [3:0] exp_q[$];
    bit mon_en = 1'b0;

    always #2 clk = ~clk;

    pm_sequencer #(.NUM_DOM(ND), .STEP_DLY(SD), .IDLE_CYC(IC), .RST_CYC(RC)) i_pm_sequencer (
        .clk(clk), .rst(rst), .dom_req(dom_req), .activity(activity), .wake_evt(wake_evt),
        .sel_shutdown(sel_shutdown), .use_gpio(use_gpio), .ctx_save_ack(ctx_save_ack),
        .ctx_valid(ctx_valid), .i2c_ack(i2c_ack), .ctx_save_req(ctx_save_req),
        .mem_selfref(mem_selfref), .reg_off_gpio(reg_off_gpio), .i2c_req(i2c_req),
        .i2c_cmd_on(i2c_cmd_on), .wake_rst(wake_rst), .dev_mode(dev_mode),
        .dom_clk_en(dom_clk_en), .dom_iso(dom_iso), .dom_ret(dom_ret), .dom_pwr(dom_pwr),
        .dom_settled(dom_settled)
    );

    function automatic logic [3:0] pat(int d);
        return {dom_clk_en[d], dom_iso[d], dom_ret[d], dom_pwr[d]};
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push(logic [3:0] p);
        exp_q.push_back(p);
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain;
        while (exp_q.size() != 0) @(negedge clk);
        while (dom_settled != '1) @(negedge clk);
        cyc(2);
    endtask

    // scoreboard monitor on domain 0
    initial begin
        logic [3:0] prev;
        int gap;
        prev = P_ACT;
        gap = 100;
        forever begin
            @(negedge clk);
            if (mon_en) begin
                gap++;
                if (pat(0) != prev) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R3 unexpected change (R11)", pat(0), prev);
                    end else begin
                        logic [3:0] e;
                        e = exp_q.pop_front();
                        check(pat(0) == e, "R3 step order", pat(0), e);
                    end
                    check(gap >= SD + 1, "R4 step spacing", gap, SD + 1);
                    gap = 0;
                    prev = pat(0);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    task automatic pulse_wake;
        activity = 1'b1;
        wake_evt = 1'b1;
        @(negedge clk);
        wake_evt = 1'b0;
    endtask

    task automatic save_ack;
        while (!ctx_save_req) @(negedge clk);
        ctx_save_ack = 1'b1;
        @(negedge clk);
        ctx_save_ack = 1'b0;
    endtask

    task automatic wakeup_and_reset(string tag);
        int n;
        n = 0;
        while (!wake_rst) @(negedge clk);
        while (wake_rst) begin
            check(dev_mode == 2'b11, tag, dev_mode, 3);
            n++;
            @(negedge clk);
        end
        check(n == RC, "R9 wake reset length", n, RC);
        check(dev_mode == 2'b00 && !mem_selfref, "R9 back to run", {dev_mode, mem_selfref}, 0);
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(pat(0) == P_ACT && pat(1) == P_ACT, "R1 domains active", {pat(1), pat(0)}, {P_ACT, P_ACT});
        check(dev_mode == 2'b00, "R1 mode", dev_mode, 0);
        check({ctx_save_req, mem_selfref, reg_off_gpio, i2c_req, wake_rst} == '0, "R1 outputs idle",
              {ctx_save_req, mem_selfref, reg_off_gpio, i2c_req, wake_rst}, 0);
        mon_en = 1'b1;

        // R2/R3: walk domain 0 through all states
        push(P_CK0);
        dom_req[1:0] = 2'b01;
        drain();
        check(pat(0) == P_CK0, "R2 inactive code", pat(0), P_CK0);
        push(P_ISO); push(P_RET);
        dom_req[1:0] = 2'b10;
        drain();
        check(pat(0) == P_RET, "R2 retention code", pat(0), P_RET);
        push(P_OFF);
        dom_req[1:0] = 2'b11;
        drain();
        check(pat(0) == P_OFF, "R2 off code", pat(0), P_OFF);
        push(4'b0101); push(P_CK0); push(P_ACT);
        dom_req[1:0] = 2'b00;
        drain();

        // R5: idle count restart, then R6 standby
        sel_shutdown = 1'b0;
        activity = 1'b0;
        cyc(15);
        activity = 1'b1;
        @(negedge clk);
        activity = 1'b0;
        push(P_CK0); push(P_ISO); push(P_RET);
        cyc(19);
        check(dev_mode == 2'b00, "R5 no early exit", dev_mode, 0);
        @(negedge clk);
        check(dev_mode == 2'b01, "R5 exit at limit", dev_mode, 1);
        drain();
        check(pat(1) == P_RET, "R6 all domains retained", pat(1), P_RET);
        // R11: request change ignored in standby
        dom_req = 4'b1111;
        cyc(12);
        check(pat(0) == P_RET && pat(1) == P_RET, "R11 request ignored", {pat(1), pat(0)}, {P_RET, P_RET});
        dom_req = '0;
        push(4'b0101); push(P_CK0); push(P_ACT);
        pulse_wake();
        check(dev_mode == 2'b00, "R10 wake from standby", dev_mode, 0);
        drain();

        // R7: fallback to standby when context not valid
        sel_shutdown = 1'b1;
        ctx_valid = 1'b0;
        activity = 1'b0;
        while (!ctx_save_req) @(negedge clk);
        cyc(4);
        check(ctx_save_req && pat(0) == P_ACT, "R7 save request held", {ctx_save_req, pat(0)}, {1'b1, P_ACT});
        push(P_CK0); push(P_ISO); push(P_RET);
        save_ack();
        check(dev_mode == 2'b01 && !ctx_save_req, "R7 fallback standby", dev_mode, 1);
        drain();
        check(!reg_off_gpio && !i2c_req && !mem_selfref, "R7 no cut", {reg_off_gpio, i2c_req, mem_selfref}, 0);
        push(4'b0101); push(P_CK0); push(P_ACT);
        pulse_wake();
        drain();

        // R8/R9 GPIO path
        ctx_valid = 1'b1;
        use_gpio = 1'b1;
        activity = 1'b0;
        push(P_CK0); push(P_ISO); push(P_OFF);
        save_ack();
        check(dev_mode == 2'b10 && mem_selfref, "R8 shutdown entry", {dev_mode, mem_selfref}, 5);
        while (!reg_off_gpio) @(negedge clk);
        check(dom_pwr == '0 && !i2c_req, "R8 gpio cut", {dom_pwr, i2c_req}, 0);
        cyc(5);
        check(reg_off_gpio && dev_mode == 2'b10, "R8 stays off", {reg_off_gpio, dev_mode}, 6);
        push(4'b0101); push(P_CK0); push(P_ACT);
        pulse_wake();
        check(!reg_off_gpio, "R9 gpio released", reg_off_gpio, 0);
        wakeup_and_reset("R9 gpio wake mode");
        drain();

        // R8/R9 I2C path
        use_gpio = 1'b0;
        activity = 1'b0;
        push(P_CK0); push(P_ISO); push(P_OFF);
        save_ack();
        while (!i2c_req) @(negedge clk);
        check(!i2c_cmd_on && !reg_off_gpio, "R8 i2c off command", {i2c_cmd_on, reg_off_gpio}, 0);
        cyc(5);
        check(i2c_req, "R8 i2c held", i2c_req, 1);
        i2c_ack = 1'b1;
        @(negedge clk);
        i2c_ack = 1'b0;
        check(!i2c_req && dev_mode == 2'b10, "R8 i2c done", {i2c_req, dev_mode}, 2);
        push(4'b0101); push(P_CK0); push(P_ACT);
        pulse_wake();
        check(i2c_req && i2c_cmd_on, "R9 i2c on command", {i2c_req, i2c_cmd_on}, 3);
        cyc(3);
        check(i2c_req && !wake_rst, "R9 wait for ack", {i2c_req, wake_rst}, 2);
        i2c_ack = 1'b1;
        @(negedge clk);
        i2c_ack = 1'b0;
        wakeup_and_reset("R9 i2c wake mode");
        drain();

        // R10: abort in the middle of shutdown domain sequencing
        use_gpio = 1'b1;
        activity = 1'b0;
        push(P_CK0); push(P_ACT);
        save_ack();
        while (pat(0) != P_CK0) @(negedge clk);
        pulse_wake();
        check(dev_mode == 2'b00 && !mem_selfref, "R10 abort to run", {dev_mode, mem_selfref}, 0);
        drain();
        check(!reg_off_gpio && dom_pwr == '1, "R10 power kept", {reg_off_gpio, dom_pwr}, 3);
        check(exp_q.size() == 0, "R3 scoreboard empty", exp_q.size(), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule